// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block merges the interrupt conditions of a UART into one prioritized identification code. Software reads that code from a read-only identification register. Five sources take part, from highest to lowest priority:

- line status
- received data available
- receive timeout
- transmit data request
- modem status

An interrupt line goes to the host. A source takes part in the code and in the line only while its enable is set.

Each source has its own way of being cleared:

- Line status, receive data and receive timeout are level inputs. The logic that detects them clears them outside this block.
- The transmit request is held inside the block. It is dropped by new transmit data, or by an identification read while it is the source being reported.
- The modem status flag is dropped only by a read of the modem status register.
- An autobaud-lock flag stands outside the priority chain. It is set when the baud detector locks and dropped by an identification read. It appears on its own output and drives the interrupt line, but it never changes the code.

The transmit request follows the FIFO mode. With the FIFOs off, it tracks the transmit holding register becoming empty. With the FIFOs on, it tracks the transmit FIFO holding half of its depth or less.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the code reads 4'b0001, and the pending flag, the autobaud flag and the interrupt line are all 0.
- R2: The code is 4'b0110 for line status, 4'b0100 for receive data, 4'b1100 for receive timeout, 4'b0010 for transmit request and 4'b0000 for modem status. The highest enabled pending source is the one reported. With nothing enabled and pending, the code is 4'b0001: bit 0 is 1 exactly when no source is reported.
- R3: A source whose enable is low does not change the code or the interrupt line. A modem change seen while the modem enable is low is still latched, and it is reported once the enable is set.
- R4: In non-FIFO mode, a transmit request becomes pending in the cycle after the holding-register-empty input rises.
- R5: In FIFO mode, a transmit request becomes pending in the cycle after the transmit FIFO occupancy changes to a value at or below TX_DEPTH/2. Occupancy above that value raises nothing.
- R6: An identification read clears the transmit request only when the code reads 4'b0010 in the cycle of the read. A read while a higher source is reported leaves the request pending.
- R7: A write of transmit data clears the transmit request.
- R8: Once cleared, the transmit request becomes pending again on the next change of FIFO occupancy while the occupancy is still at or below TX_DEPTH/2. Without such a change it stays clear.
- R9: Any of the four modem change inputs sets the modem status flag. Only a modem status read clears it; an identification read does not.
- R10: An autobaud lock pulse sets the autobaud flag and drives the interrupt line without changing the code. An identification read clears the flag.
- R11: The interrupt line is high exactly when a source is reported or the autobaud flag is set.
- R12: If a setting event and a clearing strobe fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_line | input | 1 | Enable for the line status source |
| en_rx | input | 1 | Enable for the receive data and receive timeout sources |
| en_tx | input | 1 | Enable for the transmit request source |
| en_modem | input | 1 | Enable for the modem status source |
| line_pend | input | 1 | Line status condition (level) |
| rx_pend | input | 1 | Receive data available condition (level) |
| rxto_pend | input | 1 | Receive timeout condition (level) |
| fifo_mode | input | 1 | 1 = FIFOs enabled |
| thr_empty | input | 1 | Transmit holding register empty (used in non-FIFO mode) |
| tx_level | input | LVL_W | Transmit FIFO occupancy (used in FIFO mode) |
| modem_delta | input | NUM_MODEM | Change pulses from the modem lines (CTS, DSR, RI, DCD) |
| abl_lock | input | 1 | Pulse from the baud detector when it locks |
| id_rd | input | 1 | Read strobe for the identification register |
| msr_rd | input | 1 | Read strobe for the modem status register |
| thr_wr | input | 1 | Write strobe for transmit data |
| irq_id | output | 4 | Identification code |
| irq_pending | output | 1 | 1 when an enabled source is pending |
| abl_flag | output | 1 | Autobaud lock indication |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with TX_DEPTH set to 16, so the half-full boundary sits at an occupancy of 8. That makes the 9-to-8 crossing and the re-qualification at 7 easy to drive. The autobaud variant is left enabled, so the flag and its effect on the interrupt line can be observed. The four-input modem width and the four-bit code are kept at their defaults.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   typedef enum logic [3:0] {
      ID_MODEM  = 4'b0000,
      ID_NONE   = 4'b0001,
      ID_TXREQ  = 4'b0010,
      ID_RXDATA = 4'b0100,
      ID_LINE   = 4'b0110,
      ID_RXTMO  = 4'b1100
   } irq_id_e;

   localparam int unsigned SRC_N = 5;
   localparam int unsigned SRC_MODEM = 0;
   localparam int unsigned SRC_TX    = 1;
   localparam int unsigned SRC_TMO   = 2;
   localparam int unsigned SRC_RX    = 3;
   localparam int unsigned SRC_LINE  = 4;
endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end

   assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/uart_irq_txreq.sv
module uart_irq_txreq #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_mode,
   input  logic             thr_empty,
   input  logic [LVL_W-1:0] level,
   input  logic             clr_i,
   output logic             pend_o
);
   localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);

   logic             qual, qual_q, set_ev;
   logic [LVL_W-1:0] level_q;

   assign qual   = fifo_mode ? (level <= HALF) : thr_empty;
   assign set_ev = qual && (!qual_q || (fifo_mode && (level != level_q)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qual_q  <= 1'b0;
         level_q <= '0;
         pend_o  <= 1'b0;
      end else begin
         qual_q  <= qual;
         level_q <= level;
         if (set_ev)
            pend_o <= 1'b1;
         else if (clr_i)
            pend_o <= 1'b0;
      end
   end

   assert_raise_on_qualify_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && !qual_q) |=> pend_o);
   assert_cleared_by_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_ev) |=> !pend_o);
   assert_no_raise_above_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_mode && (level > HALF) && !pend_o) |=> !pend_o);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic [SRC_N-1:0] req_i,
   output irq_id_e          id_o,
   output logic             any_o
);
   always_comb begin
      if (req_i[SRC_LINE])       id_o = ID_LINE;
      else if (req_i[SRC_RX])    id_o = ID_RXDATA;
      else if (req_i[SRC_TMO])   id_o = ID_RXTMO;
      else if (req_i[SRC_TX])    id_o = ID_TXREQ;
      else if (req_i[SRC_MODEM]) id_o = ID_MODEM;
      else                       id_o = ID_NONE;
   end

   assign any_o = |req_i;

   always_comb begin
      assert_code_lsb_R2: assert (any_o == !id_o[0]);
   end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int unsigned TX_DEPTH    = 64,
   parameter int unsigned NUM_MODEM   = 4,
   parameter bit          ABL_PRESENT = 1'b1,
   parameter int unsigned LVL_W       = $clog2(TX_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_line,
   input  logic                 en_rx,
   input  logic                 en_tx,
   input  logic                 en_modem,
   input  logic                 line_pend,
   input  logic                 rx_pend,
   input  logic                 rxto_pend,
   input  logic                 fifo_mode,
   input  logic                 thr_empty,
   input  logic [LVL_W-1:0]     tx_level,
   input  logic [NUM_MODEM-1:0] modem_delta,
   input  logic                 abl_lock,
   input  logic                 id_rd,
   input  logic                 msr_rd,
   input  logic                 thr_wr,
   output logic [3:0]           irq_id,
   output logic                 irq_pending,
   output logic                 abl_flag,
   output logic                 irq
);
   if (TX_DEPTH < 2 || (TX_DEPTH % 2) != 0) begin : g_bad_depth
      $error("uart_irq_ident: TX_DEPTH must be even and at least 2");
   end
   if (NUM_MODEM < 1) begin : g_bad_modem
      $error("uart_irq_ident: NUM_MODEM must be at least 1");
   end
   if (LVL_W < $clog2(TX_DEPTH + 1)) begin : g_bad_lvl
      $error("uart_irq_ident: LVL_W too narrow for TX_DEPTH");
   end

   logic            tx_pend, modem_pend, tx_clr;
   logic [SRC_N-1:0] req;
   irq_id_e         code;

   assign tx_clr = thr_wr || (id_rd && (code == ID_TXREQ));

   uart_irq_txreq #(.DEPTH(TX_DEPTH), .LVL_W(LVL_W)) u_txreq (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .thr_empty(thr_empty),
      .level(tx_level), .clr_i(tx_clr), .pend_o(tx_pend)
   );

   uart_irq_sticky u_modem (
      .clk(clk), .rst_n(rst_n), .set_i(|modem_delta), .clr_i(msr_rd),
      .flag_o(modem_pend)
   );

   if (ABL_PRESENT) begin : g_abl
      uart_irq_sticky u_abl (
         .clk(clk), .rst_n(rst_n), .set_i(abl_lock), .clr_i(id_rd),
         .flag_o(abl_flag)
      );
   end else begin : g_no_abl
      assign abl_flag = 1'b0;
   end

   always_comb begin
      req            = '0;
      req[SRC_LINE]  = en_line  && line_pend;
      req[SRC_RX]    = en_rx    && rx_pend;
      req[SRC_TMO]   = en_rx    && rxto_pend;
      req[SRC_TX]    = en_tx    && tx_pend;
      req[SRC_MODEM] = en_modem && modem_pend;
   end

   uart_irq_prio u_prio (.req_i(req), .id_o(code), .any_o(irq_pending));

   assign irq_id = code;
   assign irq    = irq_pending || abl_flag;

   assert_line_on_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_line && line_pend) |-> (irq_id == ID_LINE));
   assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_line && !en_rx && !en_tx && !en_modem) |-> (irq_id == ID_NONE));
   assert_abl_drives_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
      abl_flag |-> irq);
   assert_id_read_keeps_modem_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (modem_pend && !msr_rd) |=> modem_pend);
endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int LW = $clog2(DEPTH + 1);
   localparam int WATCHDOG = 20000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en_line = 0, en_rx = 0, en_tx = 0, en_modem = 0;
   logic line_pend = 0, rx_pend = 0, rxto_pend = 0, fifo_mode = 0, thr_empty = 0;
   logic [LW-1:0] tx_level = LW'(DEPTH);
   logic [3:0] modem_delta = '0;
   logic abl_lock = 0, id_rd = 0, msr_rd = 0, thr_wr = 0;
   logic [3:0] irq_id;
   logic irq_pending, abl_flag, irq;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_irq_ident #(.TX_DEPTH(DEPTH), .NUM_MODEM(4), .ABL_PRESENT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .en_line(en_line), .en_rx(en_rx), .en_tx(en_tx),
      .en_modem(en_modem), .line_pend(line_pend), .rx_pend(rx_pend),
      .rxto_pend(rxto_pend), .fifo_mode(fifo_mode), .thr_empty(thr_empty),
      .tx_level(tx_level), .modem_delta(modem_delta), .abl_lock(abl_lock),
      .id_rd(id_rd), .msr_rd(msr_rd), .thr_wr(thr_wr), .irq_id(irq_id),
      .irq_pending(irq_pending), .abl_flag(abl_flag), .irq(irq)
   );

   task automatic check(string req, logic [3:0] got, logic [3:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
      modem_delta = '0; abl_lock = 0; id_rd = 0; msr_rd = 0; thr_wr = 0;
   endtask

   task automatic t_reset();
      repeat (2) @(posedge clk);
      #1 rst_n = 1;
      tick();
      check("R1 code", irq_id, 4'b0001);
      check("R1 pending", {3'b0, irq_pending}, 4'd0);
      check("R1 abl", {3'b0, abl_flag}, 4'd0);
      check("R1 irq", {3'b0, irq}, 4'd0);
   endtask

   task automatic t_priority();
      en_line = 1; en_rx = 1; en_tx = 1; en_modem = 1;
      modem_delta = 4'b0100; tick();
      check("R9 modem set", irq_id, 4'b0000);
      check("R11 irq with modem", {3'b0, irq}, 4'd1);
      thr_empty = 1; tick();
      check("R4 tx raise", irq_id, 4'b0010);
      rxto_pend = 1; #1 check("R2 timeout", irq_id, 4'b1100);
      rx_pend = 1;   #1 check("R2 rx data", irq_id, 4'b0100);
      line_pend = 1; #1 check("R2 line", irq_id, 4'b0110);
      line_pend = 0; rx_pend = 0; rxto_pend = 0; #1;
      id_rd = 1; tick();
      check("R6 tx cleared by id read", irq_id, 4'b0000);
      id_rd = 1; tick();
      check("R9 id read keeps modem", irq_id, 4'b0000);
      msr_rd = 1; tick();
      check("R9 msr read clears", irq_id, 4'b0001);
      check("R11 irq idle", {3'b0, irq}, 4'd0);
   endtask

   task automatic t_disable();
      en_modem = 0; modem_delta = 4'b0001; tick();
      check("R3 modem masked code", irq_id, 4'b0001);
      check("R3 modem masked irq", {3'b0, irq}, 4'd0);
      en_modem = 1; #1;
      check("R3 latched modem shows", irq_id, 4'b0000);
      msr_rd = 1; tick();
      en_line = 0; line_pend = 1; #1;
      check("R3 line masked code", irq_id, 4'b0001);
      check("R3 line masked irq", {3'b0, irq}, 4'd0);
      line_pend = 0; en_line = 1;
   endtask

   task automatic t_read_other();
      thr_empty = 0; tick();
      thr_empty = 1; tick();
      line_pend = 1; id_rd = 1; tick();
      line_pend = 0; #1;
      check("R6 read of line keeps tx", irq_id, 4'b0010);
      thr_wr = 1; tick();
      check("R7 write clears tx", irq_id, 4'b0001);
      thr_empty = 0;
   endtask

   task automatic t_fifo();
      fifo_mode = 1; tx_level = LW'(12); tick();
      check("R5 above half idle", irq_id, 4'b0001);
      tx_level = LW'(9); tick();
      check("R5 nine idle", irq_id, 4'b0001);
      tx_level = LW'(8); tick();
      check("R5 half raises", irq_id, 4'b0010);
      thr_wr = 1; tick();
      check("R7 write clears fifo tx", irq_id, 4'b0001);
      tx_level = LW'(7); tick();
      check("R8 requalify", irq_id, 4'b0010);
      id_rd = 1; tick(); tick();
      check("R8 no change stays clear", irq_id, 4'b0001);
      tx_level = LW'(DEPTH); tick();
      fifo_mode = 0; tick();
   endtask

   task automatic t_same_cycle();
      modem_delta = 4'b1000; msr_rd = 1; tick();
      check("R12 modem set wins", irq_id, 4'b0000);
      msr_rd = 1; tick();
      abl_lock = 1; tick();
      check("R10 abl set", {3'b0, abl_flag}, 4'd1);
      check("R10 abl leaves code", irq_id, 4'b0001);
      check("R11 irq from abl", {3'b0, irq}, 4'd1);
      abl_lock = 1; id_rd = 1; tick();
      check("R12 abl set wins", {3'b0, abl_flag}, 4'd1);
      id_rd = 1; tick();
      check("R10 id read clears abl", {3'b0, abl_flag}, 4'd0);
      check("R11 irq low", {3'b0, irq}, 4'd0);
   endtask

   initial begin
      t_reset();
      t_priority();
      t_disable();
      t_read_other();
      t_fifo();
      t_same_cycle();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule